// File: doc/BRIEF.md
# Alarm Counter with Auto-Reset

This block is a 32-bit counter driven by a slow real-time oscillator clock. While its run input is high it advances by one on every oscillator cycle, and while run is low it keeps its value. The counter can be overwritten at any time through a load strobe and a 32-bit load value. When it passes the top of its range it wraps from all ones back to zero.

The counter is compared against a 32-bit alarm value while the alarm enable is high. The first cycle in which the count equals the alarm value produces a one-cycle alarm pulse and sets a sticky alarm flag. The surrounding logic can route that pulse or flag to an interrupt, a wake-up or a reset request. A clear strobe returns the flag to zero.

With auto-reset enabled, a running counter that matches the alarm value returns to zero on the next oscillator edge, which produces periodic alarms. Because the zero comes one cycle after the match, the period is the alarm value plus one. The alarm value must therefore be programmed as the desired period minus one.

Top module: `alarm_counter`

## Requirements
- R1: After reset, count is 0 and alarm_pulse and alarm_flag are 0.
- R2: With load low, a running counter (run = 1) increases by one per clock edge, and a stopped counter (run = 0) holds its value.
- R3: With load high, the next count is load_value, whatever the values of run, alarm and auto-reset.
- R4: A running counter at 0xFFFFFFFF goes to 0 on the next edge.
- R5: alarm_pulse is high only while alarm_en is 1 and count equals alarm_value. It is high in the first such cycle only, and it lasts one cycle. With alarm_en at 0 no pulse is produced.
- R6: While count stays at the match value, for example when stopped, no further pulse appears until the match ends and begins again.
- R7: With autoreset_en at 1, run at 1, load at 0 and an enabled match, the next count is 0. The alarm therefore repeats every alarm_value + 1 cycles.
- R8: alarm_flag is set on the edge after an alarm_pulse. It stays set until flag_clear is high at an edge. If a pulse and a clear arrive together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable |
| load | input | 1 | Load strobe, overrides counting |
| load_value | input | 32 | Value taken on load |
| alarm_value | input | 32 | Compare value |
| alarm_en | input | 1 | Enables the alarm compare |
| autoreset_en | input | 1 | Return to zero after a match |
| flag_clear | input | 1 | Clears the sticky flag |
| count | output | 32 | Current counter value |
| alarm_pulse | output | 1 | One-cycle alarm event |
| alarm_flag | output | 1 | Sticky alarm indication |

## Verification
The counter is run in three ways: free running from zero, stopped part way, and loaded just below all ones. These runs separate the increment, the hold and the wrap. Alarm matches are tried with the enable on and off, and with the counter halted on the match value. This shows whether a pulse fires at all, whether it depends on the enable, and whether a halted match repeats. Auto-reset runs count pulses over a fixed window and record the highest count seen, which exposes an off-by-one period. The flag is cleared both on its own and in the same cycle as a new pulse.

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_value,
  input  logic [W-1:0] alarm_value,
  input  logic         alarm_en,
  input  logic         autoreset_en,
  input  logic         flag_clear,
  output logic [W-1:0] count,
  output logic         alarm_pulse,
  output logic         alarm_flag
);

  logic match, was_match, wrap_now;

  assign match       = alarm_en && (count == alarm_value);
  assign alarm_pulse = match && !was_match;
  assign wrap_now    = run && autoreset_en && match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      was_match  <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      if (load)          count <= load_value;
      else if (wrap_now) count <= '0;
      else if (run)      count <= count + 1'b1;
      was_match <= match;
      if (alarm_pulse)     alarm_flag <= 1'b1;
      else if (flag_clear) alarm_flag <= 1'b0;
    end
  end

endmodule

module alarm_counter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         load,
  input logic [W-1:0] load_value,
  input logic [W-1:0] alarm_value,
  input logic         alarm_en,
  input logic         autoreset_en,
  input logic [W-1:0] count,
  input logic         alarm_pulse,
  input logic         alarm_flag
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> count == $past(count));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !(autoreset_en && alarm_en && count == alarm_value))
      |=> count == $past(count) + 1'b1);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_value));

  assert_pulse_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> (alarm_en && count == alarm_value));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> !alarm_pulse);

  assert_autoreset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && autoreset_en && alarm_en && count == alarm_value) |=> count == '0);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> alarm_flag);

endmodule

bind alarm_counter alarm_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .load(load), .load_value(load_value),
  .alarm_value(alarm_value), .alarm_en(alarm_en), .autoreset_en(autoreset_en),
  .count(count), .alarm_pulse(alarm_pulse), .alarm_flag(alarm_flag)
);

// File: tb/test_alarm_counter.sv
module test_alarm_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, load = 0, alarm_en = 0, autoreset_en = 0, flag_clear = 0;
  logic [31:0] load_value = 0, alarm_value = 0;
  logic [31:0] count;
  logic alarm_pulse, alarm_flag;

  int tests = 0, fails = 0, cycles = 0, pulses = 0;
  logic [31:0] m_count = 0, max_seen = 0;
  bit m_prev = 0, m_flag = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  alarm_counter i_alarm_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load), .load_value(load_value),
    .alarm_value(alarm_value), .alarm_en(alarm_en), .autoreset_en(autoreset_en),
    .flag_clear(flag_clear), .count(count), .alarm_pulse(alarm_pulse),
    .alarm_flag(alarm_flag)
  );

  task automatic check(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit match, pulse;
    match = alarm_en && (m_count == alarm_value);
    pulse = match && !m_prev;
    check(tag, "alarm_pulse", alarm_pulse, pulse);
    check(tag, "count", count, m_count);
    check(tag, "alarm_flag", alarm_flag, m_flag);
    if (pulse) pulses++;
    if (load) m_count = load_value;
    else if (run && autoreset_en && match) m_count = 0;
    else if (run) m_count = m_count + 1;
    m_prev = match;
    if (pulse) m_flag = 1;
    else if (flag_clear) m_flag = 0;
    @(posedge clk);
    @(negedge clk);
    if (count > max_seen) max_seen = count;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1", "reset count", count, 0);
    check("R1", "reset pulse", alarm_pulse, 0);
    check("R1", "reset flag", alarm_flag, 0);
    @(negedge clk);
    rst_n = 1;

    tag = "R2"; run = 1; idle(5);
    check("R2", "count after 5 runs", count, 5);
    run = 0; idle(3);
    check("R2", "count held", count, 5);

    tag = "R4"; load = 1; load_value = 32'hFFFF_FFFD; run = 1; cyc();
    load = 0; idle(3);
    check("R4", "count after wrap", count, 0);

    tag = "R3"; run = 0; autoreset_en = 1; load = 1; load_value = 32'h1234_5678; cyc();
    load = 0; autoreset_en = 0; idle(1);
    check("R3", "loaded while stopped", count, 32'h1234_5678);

    tag = "R5"; pulses = 0; load = 1; load_value = 0; alarm_value = 3; alarm_en = 1; cyc();
    load = 0; run = 1; idle(10);
    check("R5", "pulses in run past match", pulses, 1);
    check("R8", "flag sticky", alarm_flag, 1);

    tag = "R8"; flag_clear = 1; cyc(); flag_clear = 0; idle(1);
    check("R8", "flag cleared", alarm_flag, 0);

    tag = "R5"; pulses = 0; alarm_en = 0; load = 1; load_value = 0; cyc();
    load = 0; idle(8);
    check("R5", "no pulse when disabled", pulses, 0);

    tag = "R6"; pulses = 0; alarm_en = 1; run = 0; load = 1; load_value = 3; cyc();
    load = 0; idle(6);
    check("R6", "held match pulses", pulses, 1);

    tag = "R8"; flag_clear = 1; cyc(); flag_clear = 0;
    load = 1; load_value = 2; cyc(); load = 0; run = 1; cyc();
    flag_clear = 1; cyc(); flag_clear = 0; idle(1);
    check("R8", "set wins over clear", alarm_flag, 1);

    tag = "R7"; pulses = 0; run = 0; alarm_value = 4; autoreset_en = 1;
    load = 1; load_value = 0; cyc(); load = 0; run = 1; max_seen = 0; idle(15);
    check("R7", "pulses in 15 cycles", pulses, 3);
    check("R7", "max count", max_seen, 4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule